// File: doc/BRIEF.md
# Edge-Count Span Capture Unit

This block times a serial receive line from a falling edge to a later edge of a chosen polarity and keeps the result as a character signature. Software arms it. The unit then waits for a falling edge and starts a cycle timer. It counts edges of the selected kind and stops once the fixed target count is reached. The default target is five edges.

In rising-edge mode only an alternating byte (value 0x55, sent least-significant bit first with one start bit and one stop bit) gives five rising edges inside one character. A finished capture therefore marks that byte, and the timer holds its nine-bit-time span. In falling-edge mode the start edge counts as the first edge, so the span covers eight bit times. A driver re-arms the unit after every received byte, reads a finished capture, and uses the long span to trim its baud divisor.

The finished value sits in a single output buffer. It stays readable while the unit measures the next character.

Top module: `edge_span_capture`

## Requirements
- R1: After reset `cap_ready` is 0, `cap_span` is 0 and the unit is disarmed. Line activity before the first `arm` pulse never sets `cap_ready`.
- R2: With `count_falls` = 0 at arm time, a capture finishes on the fifth rising edge after the start falling edge. `cap_span` equals the number of clock cycles between those two edges of `rxd`. For a 0x55 byte with B cycles per bit this is 9·B.
- R3: With `count_falls` = 1 at arm time, the start falling edge counts as edge one. The capture finishes on the fourth falling edge after it, which gives 8·B for a 0x55 byte.
- R4: `count_falls` is sampled only in the cycle `arm` is high. Changing it later has no effect until the next arm.
- R5: An `arm` pulse clears `cap_ready` and discards any partial edge count. The unit then waits for a new falling edge. If `arm` and a completion fall in the same cycle, `arm` wins.
- R6: Without a re-arm, the edge count carries across character boundaries. Falling edges seen while timing in rising-edge mode do not restart the timer.
- R7: The timer saturates at 2^CNT_W−1. When it reaches that value without completing, the measurement is abandoned with no capture, and the unit waits for a new falling edge.
- R8: While `cap_ready` is 1, `cap_span` is held. A later completion does not overwrite it unless `rd_ack` is high in the same cycle.
- R9: `rd_ack` clears `cap_ready` and leaves `cap_span` unchanged. After a completion the unit keeps hunting without a re-arm, so the next qualifying character produces a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| arm | input | 1 | One-cycle arm / re-arm strobe |
| count_falls | input | 1 | Edge polarity for counting, sampled on arm (0 rising, 1 falling) |
| rd_ack | input | 1 | Read acknowledge, clears the ready flag |
| cap_ready | output | 1 | A captured span is held |
| cap_span | output | CNT_W | Captured span in clock cycles |

## Verification
Two cases are hard to reach from the ports. The first is timer saturation part-way through a measurement. The bench holds the line low for longer than the timer range, then sends a 0x55 byte. If the measurement had not been abandoned, the stale edge count and the saturated timer would give a wrong span instead of 9·B.

The second is an edge count carried across characters. The bench sends a byte with four rising edges and then one with a single rising edge, with no re-arm between them. It expects a span covering both bytes. It then repeats the sequence with a re-arm in between and expects no capture.

// File: rtl/esc_pkg.sv
package esc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_TIME = 2'd2
    } esc_state_e;
endpackage

// File: rtl/esc_edge.sv
module esc_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.sync = {e_q.sync[SYNC_STAGES-2:0], rxd};
        e_d.prev = e_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{sync: '1, prev: 1'b1};
        else        e_q <= e_d;
    end

    assign rise = e_q.sync[SYNC_STAGES-1] & ~e_q.prev;
    assign fall = ~e_q.sync[SYNC_STAGES-1] & e_q.prev;
endmodule

// File: rtl/esc_span_fsm.sv
module esc_span_fsm
    import esc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int EDGE_TARGET = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             mode_in,
    input  logic             rise,
    input  logic             fall,
    output logic             done,
    output logic [CNT_W-1:0] span
);
    localparam int EW = $clog2(EDGE_TARGET + 1);
    localparam logic [CNT_W-1:0] TMAX = {CNT_W{1'b1}};
    localparam logic [EW-1:0] LAST = EW'(EDGE_TARGET - 1);

    typedef struct packed {
        esc_state_e       state;
        logic             mode;
        logic [EW-1:0]    edges;
        logic [CNT_W-1:0] timer;
    } fsm_t;

    fsm_t f_d, f_q;
    logic hit;

    assign hit = f_q.mode ? fall : rise;

    always_comb begin
        f_d  = f_q;
        done = 1'b0;
        case (f_q.state)
            ST_HUNT: begin
                if (fall) begin
                    f_d.state = ST_TIME;
                    f_d.timer = CNT_W'(1);
                    f_d.edges = f_q.mode ? EW'(1) : '0;
                end
            end
            ST_TIME: begin
                if (hit && f_q.edges == LAST) begin
                    done      = 1'b1;
                    f_d.state = ST_HUNT;
                    f_d.edges = '0;
                    f_d.timer = '0;
                end else if (f_q.timer == TMAX) begin
                    f_d.state = ST_HUNT;
                    f_d.edges = '0;
                    f_d.timer = '0;
                end else begin
                    f_d.timer = f_q.timer + CNT_W'(1);
                    if (hit) f_d.edges = f_q.edges + EW'(1);
                end
            end
            default: ;
        endcase
        if (arm) begin
            done      = 1'b0;
            f_d.state = ST_HUNT;
            f_d.mode  = mode_in;
            f_d.edges = '0;
            f_d.timer = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{state: ST_IDLE, mode: 1'b0, edges: '0, timer: '0};
        else        f_q <= f_d;
    end

    assign span = f_q.timer;

    assert_idle_until_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == ST_IDLE && !arm) |=> f_q.state == ST_IDLE);
    assert_arm_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (f_q.state == ST_HUNT && f_q.edges == '0 && !done));
    assert_edge_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.edges < EW'(EDGE_TARGET));
    assert_sat_abandon_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == ST_TIME && f_q.timer == TMAX && !done && !arm) |=> f_q.state == ST_HUNT);
endmodule

// File: rtl/esc_result.sv
module esc_result #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             rd,
    input  logic             done,
    input  logic [CNT_W-1:0] span,
    output logic             ready,
    output logic [CNT_W-1:0] value
);
    typedef struct packed {
        logic             ready;
        logic [CNT_W-1:0] value;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (arm) begin
            h_d.ready = 1'b0;
        end else if (done && (!h_q.ready || rd)) begin
            h_d.ready = 1'b1;
            h_d.value = span;
        end else if (rd) begin
            h_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '{ready: 1'b0, value: '0};
        else        h_q <= h_d;
    end

    assign ready = h_q.ready;
    assign value = h_q.value;

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_q.ready && !rd && !arm) |=> (h_q.ready && $stable(h_q.value)));
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> (!h_q.ready && $stable(h_q.value)));
endmodule

// File: rtl/edge_span_capture.sv
module edge_span_capture #(
    parameter int CNT_W       = 16,
    parameter int EDGE_TARGET = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             arm,
    input  logic             count_falls,
    input  logic             rd_ack,
    output logic             cap_ready,
    output logic [CNT_W-1:0] cap_span
);
    logic             rise, fall, done;
    logic [CNT_W-1:0] span;

    esc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rise(rise), .fall(fall)
    );

    esc_span_fsm #(.CNT_W(CNT_W), .EDGE_TARGET(EDGE_TARGET)) u_fsm (
        .clk(clk), .rst_n(rst_n), .arm(arm), .mode_in(count_falls),
        .rise(rise), .fall(fall), .done(done), .span(span)
    );

    esc_result #(.CNT_W(CNT_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .arm(arm), .rd(rd_ack), .done(done),
        .span(span), .ready(cap_ready), .value(cap_span)
    );

    assert_arm_drops_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !cap_ready);
endmodule

// File: tb/edge_span_capture_test.sv
module edge_span_capture_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rxd = 1'b1;
    logic         arm = 1'b0;
    logic         count_falls = 1'b0;
    logic         rd_ack = 1'b0;
    logic         cap_ready;
    logic [W-1:0] cap_span;

    int checks = 0;
    int fails = 0;
    int exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    edge_span_capture #(.CNT_W(W), .EDGE_TARGET(5), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .arm(arm), .count_falls(count_falls),
        .rd_ack(rd_ack), .cap_ready(cap_ready), .cap_span(cap_span)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input int v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic send_frame(input logic [7:0] d, input int bt);
        logic [9:0] fr;
        fr = {1'b1, d, 1'b0};
        for (int i = 0; i < 10; i++) begin
            rxd = fr[i];
            repeat (bt) @(negedge clk);
        end
    endtask

    task automatic do_arm(input logic mode);
        @(negedge clk);
        count_falls = mode;
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // monitor: each new rise of cap_ready is compared with the queue head
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && cap_ready && !prev) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL unexpected capture: actual %0d expected none", cap_span);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (cap_span != W'(e)) begin
                        fails++;
                        $display("FAIL %s: actual %0d expected %0d", t, cap_span, e);
                    end
                end
            end
            prev = cap_ready;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cap_ready, 0, "R1 reset ready");
        check(cap_span, 0, "R1 reset span");

        // R1: activity before any arm
        send_frame(8'h55, 16);
        repeat (4) @(negedge clk);
        check(cap_ready, 0, "R1 no capture while disarmed");

        // R2: rising mode, 9 bit times
        do_arm(1'b0);
        push(144, "R2 rise span");
        send_frame(8'h55, 16);
        repeat (4) @(negedge clk);
        check(cap_ready, 1, "R2 ready after 0x55");

        // R8: second completion while held does not overwrite
        send_frame(8'h55, 12);
        repeat (4) @(negedge clk);
        check(cap_ready, 1, "R8 still ready");
        check(cap_span, 144, "R8 span held");

        // R9: read clears flag, value stays
        do_read();
        check(cap_ready, 0, "R9 ready cleared");
        check(cap_span, 144, "R9 span kept");

        // R9: keeps hunting without re-arm
        push(108, "R9 next capture");
        send_frame(8'h55, 12);
        repeat (4) @(negedge clk);
        do_read();

        // R3 falling mode, 8 bit times
        do_arm(1'b1);
        push(128, "R3 fall span");
        send_frame(8'h55, 16);
        repeat (4) @(negedge clk);
        do_read();

        // R4: mode pin changed after arm has no effect
        do_arm(1'b1);
        count_falls = 1'b0;
        push(128, "R4 mode latched");
        send_frame(8'h55, 16);
        repeat (4) @(negedge clk);
        do_read();

        // R6: partial count carries without re-arm (4 rises then 1)
        do_arm(1'b0);
        send_frame(8'hAA, 8);
        check(cap_ready, 0, "R6 four rises no capture");
        push(152, "R6 carried span");
        send_frame(8'h00, 8);
        repeat (4) @(negedge clk);
        do_read();

        // R5: re-arm discards partial count
        do_arm(1'b0);
        send_frame(8'hAA, 8);
        do_arm(1'b0);
        send_frame(8'h00, 8);
        repeat (4) @(negedge clk);
        check(cap_ready, 0, "R5 partial discarded");

        // R5: arm clears a held capture
        do_arm(1'b0);
        push(144, "R5 capture before re-arm");
        send_frame(8'h55, 16);
        repeat (4) @(negedge clk);
        do_arm(1'b0);
        check(cap_ready, 0, "R5 arm clears ready");

        // R7: saturation abandons measurement
        rxd = 1'b0;
        repeat (300) @(negedge clk);
        rxd = 1'b1;
        repeat (20) @(negedge clk);
        check(cap_ready, 0, "R7 no capture on saturation");
        push(144, "R7 fresh span after abandon");
        send_frame(8'h55, 16);
        repeat (4) @(negedge clk);
        do_read();

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule